// File: doc/BRIEF.md
# Selectable-Rate UART Transmitter

This block turns one 8-bit byte into an asynchronous serial frame on a single output line. A frame has one start bit, eight data bits and one stop bit, with no parity. The baud rate is picked at run time by a 3-bit rate code. The block runs directly on the system clock. Each bit lasts a whole number of system clock cycles, and that number is taken from a constant table built from the clock frequency parameter.

A user places a byte on the data input, sets the rate code and raises the start input. The block captures the byte and the rate on the rising edge of start and raises its busy flag. The busy flag stays high until the stop bit has been sent in full, so it can drive an activity indicator directly. A request that arrives while a frame is in flight is dropped. A start level that is held high produces only one frame.

Top module: `uart_tx_rate_sel`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx` is high and `busy` is low.
- R2: A rising edge on `start` (start high in a cycle where it was low in the cycle before), while `busy` is low, is accepted at that clock edge. From the next cycle on, `busy` is high and `tx` is low for the start bit.
- R3: A frame is sent in this order: a low start bit, then `data_in` bits 0 through 7 (least significant bit first, bit 7 is the most significant bit), then a high stop bit. Each bit lasts exactly D cycles.
- R4: D is CLK_HZ/baud rounded to the nearest integer. The baud rate comes from `rate_sel`: 0→2400, 1→4800, 2→9600, 3→19200, 4→38400, 5→57600, 6→115200, 7→115200. With the default 100 MHz clock this gives 41667, 20833, 10417, 5208, 2604, 1736 and 868 cycles.
- R5: `busy` stays high for exactly 10·D consecutive cycles per frame. It falls in the cycle after the stop bit's last cycle, and `tx` stays high at that point.
- R6: The byte and the rate code are captured when start is accepted. Changing `data_in` or `rate_sel` during a frame does not change that frame's bits or its length.
- R7: A rising edge of `start` while `busy` is high is ignored. If `start` is held high, only one frame is sent: `busy` stays low after that frame until `start` goes low and rises again.
- R8: A start edge in the first cycle after `busy` falls is accepted. The line goes straight from the stop bit into the next start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 3 | Baud rate code, captured at start |
| data_in | input | 8 | Byte to send, captured at start |
| start | input | 1 | Send request; acted on at its rising edge |
| tx | output | 1 | Serial output line, idles high |
| busy | output | 1 | High while a frame is being sent |

## Verification
The bench targets the following corner cases:

- **Rate table ends.** Both of the two top rate codes are used. A table indexed one entry off, or with the wrong rounding, would give a frame that is one or more bit-times longer or shorter.
- **Bit order.** Bytes with asymmetric bit patterns are sent. An MSB-first design would put the mirrored pattern on the line.
- **Changes during a frame.** `data_in` and `rate_sel` are changed in mid-frame. A design that reads its inputs live would change its bit values or bit lengths.
- **Held start.** `start` is held high across the end of a frame. A level-triggered design would send a second frame.
- **Start while busy.** A request arrives during a frame. A design that does not gate requests on `busy` would restart or stretch the frame.
- **Back-to-back frames.** A request arrives in the very first idle cycle. An off-by-one in the idle check would delay acceptance by a cycle or lose the request.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DATA_BITS  = 8;
    localparam int FRAME_BITS = DATA_BITS + 2;   // start + data + stop
    localparam int RATE_CODES = 8;

    typedef logic [2:0] rate_code_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        rate_code_t           rate;
    } tx_req_t;

    function automatic int unsigned baud_for_code(rate_code_t code);
        case (code)
            3'd0:    return 2400;
            3'd1:    return 4800;
            3'd2:    return 9600;
            3'd3:    return 19200;
            3'd4:    return 38400;
            3'd5:    return 57600;
            default: return 115200;
        endcase
    endfunction

    // Clock cycles per bit, rounded to nearest.
    function automatic int unsigned bit_cycles(int unsigned clk_hz, rate_code_t code);
        int unsigned b;
        b = baud_for_code(code);
        return (clk_hz + b / 2) / b;
    endfunction

    function automatic int unsigned max_bit_cycles(int unsigned clk_hz);
        return bit_cycles(clk_hz, 3'd0);
    endfunction

endpackage

// File: rtl/uart_tx_baud_gen.sv
module uart_tx_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    input  logic             run,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            div_q <= div_in;
            cnt_q <= div_in - DIV_W'(1);
        end else if (run) begin
            if (cnt_q == '0) cnt_q <= div_q - DIV_W'(1);
            else             cnt_q <= cnt_q - DIV_W'(1);
        end
    end

    assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  logic              shift,
    input  logic              finish,
    output logic              tx
);
    // Holds the data bits followed by the stop bit; shifts out LSB first.
    logic [DATA_W:0] sh_q;
    logic            tx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '1;
            tx_q <= 1'b1;
        end else if (load) begin
            sh_q <= {1'b1, data};
            tx_q <= 1'b0;
        end else if (shift) begin
            tx_q <= sh_q[0];
            sh_q <= {1'b1, sh_q[DATA_W:1]};
        end else if (finish) begin
            tx_q <= 1'b1;
        end
    end

    assign tx = tx_q;
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
    import uart_tx_pkg::*;
#(
    parameter int NBITS = FRAME_BITS
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tick,
    output logic accept,
    output logic shift,
    output logic finish,
    output logic busy
);
    localparam int CNT_W = $clog2(NBITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NBITS - 1);

    tx_state_e        state_q;
    logic [CNT_W-1:0] bit_q;
    logic             start_d;
    logic             at_last;

    assign at_last = (bit_q == LAST);
    assign accept  = (state_q == ST_IDLE) && start && !start_d;
    assign shift   = (state_q == ST_SEND) && tick && !at_last;
    assign finish  = (state_q == ST_SEND) && tick && at_last;
    assign busy    = (state_q == ST_SEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            start_d <= 1'b0;
        end else begin
            start_d <= start;
            if (accept) begin
                state_q <= ST_SEND;
                bit_q   <= '0;
            end else if (finish) begin
                state_q <= ST_IDLE;
            end else if (shift) begin
                bit_q <= bit_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/uart_tx_rate_sel.sv
module uart_tx_rate_sel
    import uart_tx_pkg::*;
#(
    parameter int unsigned CLK_HZ = 100_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] rate_sel,
    input  logic [7:0] data_in,
    input  logic       start,
    output logic       tx,
    output logic       busy
);
    localparam int DIV_W = $clog2(max_bit_cycles(CLK_HZ) + 1);

    tx_req_t          req;
    logic [DIV_W-1:0] div_tab [RATE_CODES];
    logic [DIV_W-1:0] div_sel;
    logic             accept, shift, finish, tick;

    assign req = '{data: data_in, rate: rate_sel};

    for (genvar g = 0; g < RATE_CODES; g++) begin : g_rate
        assign div_tab[g] = DIV_W'(bit_cycles(CLK_HZ, 3'(g)));
    end

    assign div_sel = div_tab[req.rate];

    uart_tx_ctrl #(.NBITS(FRAME_BITS)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .tick   (tick),
        .accept (accept),
        .shift  (shift),
        .finish (finish),
        .busy   (busy)
    );

    uart_tx_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .div_in (div_sel),
        .run    (busy),
        .tick   (tick)
    );

    uart_tx_shifter #(.DATA_W(DATA_BITS)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .data   (req.data),
        .shift  (shift),
        .finish (finish),
        .tx     (tx)
    );
endmodule

// File: rtl/uart_tx_rate_sel_checker.sv
module uart_tx_rate_sel_checker
    import uart_tx_pkg::*;
#(
    parameter int unsigned CLK_HZ = 100_000_000
) (
    input logic       clk,
    input logic       rst,
    input logic [2:0] rate_sel,
    input logic       tx,
    input logic       busy
);
    int unsigned busy_cnt;
    int unsigned exp_div;
    logic [2:0]  rate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= 0;
            exp_div  <= 0;
            rate_q   <= '0;
        end else begin
            rate_q <= rate_sel;
            if (busy) busy_cnt <= busy_cnt + 1;
            else      busy_cnt <= 0;
            if (busy && busy_cnt == 0) exp_div <= bit_cycles(CLK_HZ, rate_q);
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tx && !busy));

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx);

    assert_start_bit_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !tx);

    assert_stop_bit_high_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(tx));

    assert_frame_length_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_cnt == 10 * exp_div));
endmodule

bind uart_tx_rate_sel uart_tx_rate_sel_checker #(.CLK_HZ(CLK_HZ)) u_checker (
    .clk      (clk),
    .rst      (rst),
    .rate_sel (rate_sel),
    .tx       (tx),
    .busy     (busy)
);

// File: tb/uart_tx_rate_sel_test.sv
module uart_tx_rate_sel_test;
    localparam int unsigned CLK_HZ = 1_000_000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] rate_sel = '0;
    logic [7:0] data_in = '0;
    logic       start = 1'b0;
    logic       tx, busy;

    int errors = 0;
    int checks = 0;
    bit model_on = 0;

    always #4 clk = ~clk;   // 125 MHz

    uart_tx_rate_sel #(.CLK_HZ(CLK_HZ)) uut (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .data_in(data_in),
        .start(start), .tx(tx), .busy(busy)
    );

    function automatic int exp_div(input int code);
        int b;
        case (code)
            0: b = 2400;   1: b = 4800;  2: b = 9600;  3: b = 19200;
            4: b = 38400;  5: b = 57600; default: b = 115200;
        endcase
        return (CLK_HZ + b / 2) / b;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference model
    bit       m_busy = 0, m_tx = 1, m_prev = 0;
    int       m_cyc = 0, m_div = 1;
    bit [9:0] m_frame;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_tx = 1; m_prev = 0;
        end else begin
            if (m_busy) begin
                m_cyc++;
                if (m_cyc == 10 * m_div) begin m_busy = 0; m_tx = 1; end
                else m_tx = m_frame[m_cyc / m_div];
            end else if (start && !m_prev) begin
                m_busy = 1; m_div = exp_div(int'(rate_sel));
                m_frame = {1'b1, data_in, 1'b0}; m_cyc = 0; m_tx = 0;
            end
            m_prev = start;
        end
    end

    always @(negedge clk) begin
        if (model_on && !rst) begin
            check(busy == m_busy, "R5", "busy vs model", int'(busy), int'(m_busy));
            check(tx == m_tx, m_busy ? "R3" : "R1", "tx vs model", int'(tx), int'(m_tx));
        end
    end

    task automatic launch(input logic [2:0] c, input logic [7:0] d);
        @(negedge clk); rate_sel = c; data_in = d; start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy && !tx, "R2", "busy/start bit after accept", {busy, tx}, 2'b10);
    endtask

    // Called at the first negedge with busy high; returns at first idle negedge.
    task automatic measure(input int exp_len, input string req, input bit scramble);
        int n = 1;
        @(negedge clk);
        while (busy) begin
            n++;
            if (scramble && n == 3) begin data_in = ~data_in; rate_sel = ~rate_sel; end
            @(negedge clk);
        end
        check(n == exp_len, req, "busy length", n, exp_len);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R3 watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        model_on = 1;
        @(negedge clk);
        check(tx && !busy, "R1", "idle after reset", {tx, busy}, 2'b10);

        // R4: every rate code, asymmetric bytes
        for (int c = 0; c < 8; c++) begin
            launch(3'(c), 8'h31 + 8'(c * 17));
            measure(10 * exp_div(c), "R4", 1'b0);
        end

        // R6: inputs changed mid-frame
        launch(3'd5, 8'hA5);
        measure(10 * exp_div(5), "R6", 1'b1);

        // R7: held start sends one frame only
        @(negedge clk); rate_sel = 3'd6; data_in = 8'h3C; start = 1'b1;
        @(negedge clk);
        check(busy, "R7", "held start accepted", int'(busy), 1);
        measure(10 * exp_div(6), "R7", 1'b0);
        repeat (30) begin
            @(negedge clk);
            check(!busy && tx, "R7", "held start no second frame", {busy, tx}, 2'b01);
        end
        start = 1'b0;

        // R7: start edge during a frame is ignored
        launch(3'd7, 8'hC3);
        repeat (20) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (busy) @(negedge clk);
        repeat (20) begin
            @(negedge clk);
            check(!busy, "R7", "mid-frame start ignored", int'(busy), 0);
        end

        // R8: back-to-back frame
        launch(3'd6, 8'h81);
        while (busy) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy && !tx, "R8", "immediate restart", {busy, tx}, 2'b10);
        measure(10 * exp_div(6), "R8", 1'b0);

        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule